// File: doc/BRIEF.md
# Oneshot/Periodic Down-Counting Timer Channel

This block is one channel of a down-counting event timer. A system places several copies side by side, each one decoding an 8-byte window of a shared register space. The channel advances on a count-enable input, which is either a slow tick or every cycle of its own clock, depending on a build parameter. Software arms the channel with one control word. That word holds an enable bit, a mode bit and a 29-bit preset. The preset follows the n+1 convention: a value of N expires on the (N+1)th advance.

When the count runs out, the channel raises a level interrupt. The interrupt stays up until software clears it. In periodic mode the counter reloads the preset and keeps running. In oneshot mode the enable drops and the counter rests at zero. A second register reports the live count and the pending flag, and it accepts the clear. Writing zero to the control word stops the channel.

Top module: `oneshot_periodic_timer`

## Requirements
- R1: After reset, the control word reads 0x00000000, the status word reads 0x00000000 and `irq` is low.
- R2: A write to offset 0x0 stores bit 31 as enable, bit 30 as periodic and bits 28:0 as the preset. Bit 29 is not stored. A read of 0x0 returns {enable, periodic, 0, preset}. If the written enable is 1, the counter takes the preset on the same edge, and this takes priority over an advance in that cycle.
- R3: While enabled, the counter decreases by one on each cycle with `tick` high. It holds its value when `tick` is low or when the channel is disabled.
- R4: A preset of N produces the expiry on the (N+1)th advance after arming, so a preset of 0 expires on the first advance.
- R5: In oneshot mode (bit 30 = 0), an expiry clears the enable bit and the counter stays at 0.
- R6: In periodic mode (bit 30 = 1), an expiry reloads the preset into the counter and the channel stays enabled.
- R7: Every expiry sets `irq`, and `irq` stays high until a clear.
- R8: A read of offset 0x4 returns the current count in bits 28:0 and the pending flag in bit 30. All other bits read 0.
- R9: A write to offset 0x4 with bit 30 = 1 clears the pending flag. A write with bit 30 = 0 leaves it unchanged. If an expiry and a clear fall in the same cycle, the flag ends up set.
- R10: Writing 0 to offset 0x0 stops the channel. Later advances leave the count unchanged and raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-advance enable (ignored when USE_TICK = 0) |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Byte offset within the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Latched level interrupt |

## Verification
Two pairs of events can land in the same cycle, and the bench provokes both. In the first case, a periodic channel with preset 1 is stepped to a count of zero. The bench then raises `tick` in the same cycle as a clear write. The flag must still be set afterwards, and the count must have reloaded to 1. In the second case, an arming write is issued while `tick` is high. The count read back must equal the new preset, not the preset minus one. Each result is judged by reading the status word through the bus in the following cycle.

// File: rtl/oneshot_periodic_timer.sv
module oneshot_periodic_timer #(
  parameter int CNT_W    = 29,
  parameter bit USE_TICK = 1'b1,
  parameter int AW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] CTRL_OFS = AW'(0);
  localparam logic [AW-1:0] STAT_OFS = AW'(4);
  localparam int PAD = 30 - CNT_W;

  logic             en, per, irq_q, adv;
  logic [CNT_W-1:0] preset, cnt;

  generate
    if (USE_TICK) begin : g_tick
      assign adv = tick;
    end else begin : g_free
      assign adv = 1'b1;
    end
  endgenerate

  wire ctrl_wr = bus_we && (bus_addr == CTRL_OFS);
  wire clr     = bus_we && (bus_addr == STAT_OFS) && bus_wdata[30];
  wire zero    = (cnt == '0);
  wire expire  = en && adv && zero && !ctrl_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      per    <= 1'b0;
      preset <= '0;
      cnt    <= '0;
    end else if (ctrl_wr) begin
      en     <= bus_wdata[31];
      per    <= bus_wdata[30];
      preset <= bus_wdata[CNT_W-1:0];
      if (bus_wdata[31]) cnt <= bus_wdata[CNT_W-1:0];
    end else if (en && adv) begin
      if (!zero)    cnt <= cnt - 1'b1;
      else if (per) cnt <= preset;
      else          en  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (expire) irq_q <= 1'b1;
    else if (clr)    irq_q <= 1'b0;
  end

  assign irq = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFS)      bus_rdata = {en, per, {PAD{1'b0}}, preset};
    else if (bus_addr == STAT_OFS) bus_rdata = {1'b0, irq_q, {PAD{1'b0}}, cnt};
  end

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv && !zero && !ctrl_wr) |=> (cnt == $past(cnt) - 1'b1));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && (!en || !adv)) |=> $stable(cnt));
  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !per && adv && zero && !ctrl_wr) |=> (!en && irq && cnt == '0));
  // R6
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && per && adv && zero && !ctrl_wr) |=> (en && irq && cnt == $past(preset)));
  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_we && bus_addr == STAT_OFS && bus_wdata[30])) |=> irq);
  // R2
  arm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[31]) |=> (en && cnt == $past(bus_wdata[CNT_W-1:0])));
endmodule

// File: tb/sim_oneshot_periodic_timer.sv
module sim_oneshot_periodic_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        rd_strobe = 1'b0;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  string       q_req[$];
  logic [31:0] q_exp[$];
  bit          q_irq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  oneshot_periodic_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(negedge clk) begin
    if (rd_strobe && q_req.size() > 0) begin
      string       r;
      logic [31:0] e, a;
      bit          is_irq;
      r = q_req.pop_front();
      e = q_exp.pop_front();
      is_irq = q_irq.pop_front();
      a = is_irq ? {31'd0, irq} : bus_rdata;
      n_tests++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: actual %08h expected %08h", r, a, e);
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step(1);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic tk(int n);
    tick = 1'b1; step(n); tick = 1'b0;
  endtask

  task automatic chk_rd(logic [2:0] a, logic [31:0] e, string r);
    bus_addr = a; rd_strobe = 1'b1;
    q_req.push_back(r); q_exp.push_back(e); q_irq.push_back(1'b0);
    step(1);
    rd_strobe = 1'b0;
  endtask

  task automatic chk_irq(bit e, string r);
    rd_strobe = 1'b1;
    q_req.push_back(r); q_exp.push_back({31'd0, e}); q_irq.push_back(1'b1);
    step(1);
    rd_strobe = 1'b0;
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    chk_rd(3'h0, 32'h0, "R1 ctrl");
    chk_rd(3'h4, 32'h0, "R1 status");
    chk_irq(1'b0, "R1 irq");

    wr(3'h0, 32'h8000_0003);
    chk_rd(3'h4, 32'h0000_0003, "R2 load on arm");
    tk(3);
    chk_rd(3'h4, 32'h0000_0000, "R3 decrement");
    chk_irq(1'b0, "R4 no early expiry");
    tk(1);
    chk_irq(1'b1, "R4 expiry on N+1");
    chk_rd(3'h0, 32'h0000_0003, "R5 enable cleared");
    tk(5);
    chk_rd(3'h4, 32'h4000_0000, "R5 R7 R8 rest and held");
    wr(3'h4, 32'hBFFF_FFFF);
    chk_irq(1'b1, "R9 bit30 zero ignored");
    wr(3'h4, 32'h4000_0000);
    chk_rd(3'h4, 32'h0000_0000, "R9 cleared");

    wr(3'h0, 32'h8000_0000);
    tk(1);
    chk_irq(1'b1, "R4 preset zero");
    wr(3'h4, 32'h4000_0000);

    wr(3'h0, 32'hC000_0002);
    tk(3);
    chk_rd(3'h4, 32'h4000_0002, "R6 reload");
    chk_rd(3'h0, 32'hC000_0002, "R6 still enabled");
    wr(3'h4, 32'h4000_0000);
    step(5);
    chk_rd(3'h4, 32'h0000_0002, "R3 hold without tick");
    tk(3);
    chk_irq(1'b1, "R6 second period");
    wr(3'h4, 32'h4000_0000);

    wr(3'h0, 32'h0);
    tk(4);
    chk_rd(3'h4, 32'h0000_0002, "R10 stopped count");
    chk_irq(1'b0, "R10 no irq");
    chk_rd(3'h0, 32'h0, "R10 ctrl");

    wr(3'h0, 32'hC000_0001);
    tk(1);
    tick = 1'b1;
    wr(3'h4, 32'h4000_0000);
    tick = 1'b0;
    chk_rd(3'h4, 32'h4000_0001, "R9 expiry beats clear");
    wr(3'h4, 32'h4000_0000);
    chk_irq(1'b0, "R9 later clear");

    tick = 1'b1;
    wr(3'h0, 32'h8000_0005);
    tick = 1'b0;
    chk_rd(3'h4, 32'h0000_0005, "R2 write beats tick");

    wr(3'h0, 32'hBFFF_FFFF);
    chk_rd(3'h0, 32'h9FFF_FFFF, "R2 field layout");
    chk_rd(3'h4, 32'h1FFF_FFFF, "R8 max preset");
    tk(1);
    chk_rd(3'h4, 32'h1FFF_FFFE, "R3 max decrement");

    step(2);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule